// File: doc/BRIEF.md
# AXI Command Issue Throttle

This block sits on one channel (read or write) between an AXI master in programmable logic and a wider AXI slave on the system side. It accepts address commands into a small in-order queue. It then decides, cycle by cycle, whether the command at the head of the queue may go downstream. Three conditions must all hold for a command to issue. The total number of commands in flight must be below a programmable limit. The command's transaction ID must either already be in flight or fit under a cap on distinct IDs in flight. The companion data FIFO must have room for the command's beats once the beats already promised to earlier commands are counted.

A completion comes back from downstream as a write response, or as the last read beat. It passes to the master unchanged and is not acknowledged early. A completion that carries the last flag and is accepted by the master retires one in-flight command of that ID. The current queue fill is exported so that the surrounding logic can watch occupancy.

Top module: `axi_issue_gate`

## Requirements
- R1: After reset the block shows `up_ready`=1, `dn_valid`=0 and `q_level`=0.
- R2: The queue holds 8 commands. `up_ready` is 0 exactly when 8 are held. `q_level` gives the number held. An accepted command reaches the head no earlier than the cycle after it is accepted.
- R3: At most 8 distinct IDs are in flight. A head command whose ID is not in flight waits while 8 distinct IDs are in flight. A head command whose ID is already in flight shares that ID's entry and is not blocked by the cap.
- R4: The total in flight never exceeds the effective limit. A `limit_cfg` value above 16 acts as 16.
- R5: A `limit_cfg` value of 0 acts as 1.
- R6: The limit is taken from `limit_cfg` only while nothing is in flight. A change made while commands are in flight takes effect once all of them have retired.
- R7: The head issues only if (`dn_len`+1) plus the reserved beat count is at most `space_free`. Each issue adds `dn_len`+1 to the reservation, and each cycle with `beat_release`=1 removes one beat from it.
- R8: Commands leave strictly in the order they were accepted. A blocked head holds back every command behind it.
- R9: `up_cmp_valid`/`up_cmp_id` follow `cmp_valid`/`cmp_id`, and `cmp_ready` follows `up_cmp_ready`. A handshake with `cmp_last`=1 retires one command of that ID. When an ID's count reaches zero, its entry is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream command valid |
| up_ready | output | 1 | Queue can accept a command |
| up_id | input | 4 | Upstream command ID |
| up_len | input | 8 | Upstream burst length minus one |
| up_addr | input | 32 | Upstream address |
| dn_valid | output | 1 | Head command is eligible to issue |
| dn_ready | input | 1 | Downstream accepts the command |
| dn_id | output | 4 | Issued command ID |
| dn_len | output | 8 | Issued burst length minus one |
| dn_addr | output | 32 | Issued address |
| cmp_valid | input | 1 | Downstream completion valid |
| cmp_ready | output | 1 | Completion accepted (passes through from upstream) |
| cmp_id | input | 4 | Completion ID |
| cmp_last | input | 1 | Completion closes its transaction |
| up_cmp_valid | output | 1 | Completion toward the master |
| up_cmp_ready | input | 1 | Master accepts the completion |
| up_cmp_id | output | 4 | Completion ID toward the master |
| limit_cfg | input | 5 | Programmable in-flight limit |
| space_free | input | 8 | Free beats in the data FIFO |
| beat_release | input | 1 | One reserved beat consumed |
| q_level | output | 4 | Commands held in the queue |

## Verification
`dn_valid`, the head fields, `up_ready` and `q_level` all come straight from registered state and the current inputs. They are therefore due in the same cycle as the inputs that affect them. A handshake, a completion or a release changes them only from the next cycle. The completion path is purely combinational and is due in the same cycle. The bench sets its inputs at the falling edge and compares just after, against a model whose state it advances at the rising edge using the handshakes it predicted. Every comparison therefore lines up with the cycle in which each result becomes due.

// File: rtl/axi_gate_pkg.sv
package axi_gate_pkg;
   // Effective issue limit: zero acts as one, values above the cap saturate.
   function automatic int unsigned clamp_limit(int unsigned v, int unsigned cap);
      if (v == 0) return 1;
      if (v > cap) return cap;
      return v;
   endfunction
endpackage

// File: rtl/gate_cmd_queue.sv
module gate_cmd_queue #(
   parameter int W     = 44,
   parameter int DEPTH = 8
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             in_valid,
   output logic                             in_ready,
   input  logic [W-1:0]                     in_data,
   output logic                             out_valid,
   output logic [W-1:0]                     out_data,
   input  logic                             out_pop,
   output logic [$clog2(DEPTH+1)-1:0]       level
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH+1);

   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
      $error("gate_cmd_queue: DEPTH must be a power of two of at least 2");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [LVL_W-1:0] cnt;
   logic             push, pop;

   assign in_ready  = (cnt != LVL_W'(DEPTH));
   assign out_valid = (cnt != '0);
   assign out_data  = mem[rd_ptr];
   assign level     = cnt;
   assign push      = in_valid && in_ready;
   assign pop       = out_pop && out_valid;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= in_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PTR_W'(1);
         if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
         cnt <= cnt + LVL_W'(push) - LVL_W'(pop);
      end
   end

   p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LVL_W'(DEPTH));
   p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready && !out_pop) |=> $stable(cnt));
endmodule

// File: rtl/gate_id_tracker.sv
module gate_id_tracker #(
   parameter int ID_W  = 4,
   parameter int SLOTS = 8,
   parameter int CNT_W = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue,
   input  logic [ID_W-1:0] issue_id,
   input  logic            retire,
   input  logic [ID_W-1:0] retire_id,
   output logic            hit,
   output logic            room,
   output logic            retire_hit
);
   if (SLOTS < 1 || CNT_W < 1) begin : g_bad_cfg
      $error("gate_id_tracker: SLOTS and CNT_W must be positive");
   end

   logic [SLOTS-1:0] vld, hit_v, rhit_v, alloc_v;
   logic [ID_W-1:0]  ids [SLOTS];
   logic [CNT_W-1:0] cnt [SLOTS];

   always_comb begin
      alloc_v = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (!vld[i] && alloc_v == '0) alloc_v[i] = 1'b1;
      end
   end

   assign hit        = |hit_v;
   assign room       = ~&vld;
   assign retire_hit = |rhit_v;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      logic             inc, dec;
      logic [CNT_W-1:0] nxt;
      assign hit_v[i]  = vld[i] && (ids[i] == issue_id);
      assign rhit_v[i] = vld[i] && (ids[i] == retire_id);
      assign inc = issue && (hit_v[i] || (!hit && alloc_v[i]));
      assign dec = retire && rhit_v[i];
      assign nxt = cnt[i] + CNT_W'(inc) - CNT_W'(dec);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[i] <= 1'b0;
            cnt[i] <= '0;
            ids[i] <= '0;
         end else begin
            cnt[i] <= nxt;
            vld[i] <= (nxt != '0);
            if (inc && !vld[i]) ids[i] <= issue_id;
         end
      end
   end

   p_alloc_has_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !hit) |-> room);
   p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_v));
endmodule

// File: rtl/axi_issue_gate.sv
module axi_issue_gate #(
   parameter int ID_W      = 4,
   parameter int LEN_W     = 8,
   parameter int ADDR_W    = 32,
   parameter int QDEPTH    = 8,
   parameter int ID_SLOTS  = 8,
   parameter int MAX_ISSUE = 16,
   parameter int SPACE_W   = 8,
   parameter int LIM_W     = 5
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          up_valid,
   output logic                          up_ready,
   input  logic [ID_W-1:0]               up_id,
   input  logic [LEN_W-1:0]              up_len,
   input  logic [ADDR_W-1:0]             up_addr,
   output logic                          dn_valid,
   input  logic                          dn_ready,
   output logic [ID_W-1:0]               dn_id,
   output logic [LEN_W-1:0]              dn_len,
   output logic [ADDR_W-1:0]             dn_addr,
   input  logic                          cmp_valid,
   output logic                          cmp_ready,
   input  logic [ID_W-1:0]               cmp_id,
   input  logic                          cmp_last,
   output logic                          up_cmp_valid,
   input  logic                          up_cmp_ready,
   output logic [ID_W-1:0]               up_cmp_id,
   input  logic [LIM_W-1:0]              limit_cfg,
   input  logic [SPACE_W-1:0]            space_free,
   input  logic                          beat_release,
   output logic [$clog2(QDEPTH+1)-1:0]   q_level
);
   localparam int OUT_W = $clog2(MAX_ISSUE+1);
   localparam int PK_W  = ID_W + LEN_W + ADDR_W;
   localparam int CMP_W = ((SPACE_W > LEN_W+1) ? SPACE_W : LEN_W+1) + 1;

   if (MAX_ISSUE < 1 || (1 << LIM_W) <= MAX_ISSUE) begin : g_bad_limit
      $error("axi_issue_gate: LIM_W too narrow for MAX_ISSUE");
   end

   logic             head_vld, issue, retire, cmp_fire;
   logic             id_hit, id_room, ret_hit;
   logic [PK_W-1:0]  head;
   logic [OUT_W-1:0] out_cnt, lim_q, lim_cfg_c, lim_eff;
   logic [SPACE_W-1:0] resv;
   logic [CMP_W-1:0] need;
   logic             ok_lim, ok_id, ok_space;

   gate_cmd_queue #(.W(PK_W), .DEPTH(QDEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .in_valid(up_valid), .in_ready(up_ready), .in_data({up_id, up_len, up_addr}),
      .out_valid(head_vld), .out_data(head), .out_pop(issue), .level(q_level));

   assign {dn_id, dn_len, dn_addr} = head;

   gate_id_tracker #(.ID_W(ID_W), .SLOTS(ID_SLOTS), .CNT_W(OUT_W)) u_ids (
      .clk(clk), .rst_n(rst_n),
      .issue(issue), .issue_id(dn_id),
      .retire(cmp_fire), .retire_id(cmp_id),
      .hit(id_hit), .room(id_room), .retire_hit(ret_hit));

   // Completion path: straight through, no early response.
   assign up_cmp_valid = cmp_valid;
   assign up_cmp_id    = cmp_id;
   assign cmp_ready    = up_cmp_ready;
   assign cmp_fire     = cmp_valid && up_cmp_ready && cmp_last;
   assign retire       = cmp_fire && ret_hit && (out_cnt != '0);

   assign lim_cfg_c = OUT_W'(axi_gate_pkg::clamp_limit(int'(limit_cfg), MAX_ISSUE));
   assign lim_eff   = (out_cnt == '0) ? lim_cfg_c : lim_q;

   assign need     = CMP_W'(dn_len) + CMP_W'(1);
   assign ok_lim   = out_cnt < lim_eff;
   assign ok_id    = id_hit || id_room;
   assign ok_space = (CMP_W'(resv) + need) <= CMP_W'(space_free);
   assign dn_valid = head_vld && ok_lim && ok_id && ok_space;
   assign issue    = dn_valid && dn_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_cnt <= '0;
         lim_q   <= OUT_W'(1);
         resv    <= '0;
      end else begin
         if (out_cnt == '0) lim_q <= lim_cfg_c;
         out_cnt <= out_cnt + OUT_W'(issue) - OUT_W'(retire);
         resv    <= resv + (issue ? SPACE_W'(need) : '0)
                         - SPACE_W'(beat_release && resv != '0);
      end
   end

   p_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_cnt != '0) |-> (out_cnt <= lim_q));
   p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_cnt <= OUT_W'(MAX_ISSUE));
   p_hold_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(out_cnt) != '0) |-> $stable(lim_q));
   p_retire_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
      retire |=> (out_cnt == $past(out_cnt) + OUT_W'($past(issue)) - OUT_W'(1)));
endmodule

// File: tb/axi_issue_gate_tb.sv
module axi_issue_gate_tb;
   localparam int CLK_P = 10;

   typedef struct {int id; int len; int addr;} cmd_t;

   logic clk = 0, rst_n = 0;
   logic up_valid = 0, dn_ready = 0, cmp_valid = 0, cmp_last = 0, up_cmp_ready = 0, beat_release = 0;
   logic [3:0] up_id = 0, cmp_id = 0;
   logic [7:0] up_len = 0, space_free = 8'd255;
   logic [31:0] up_addr = 0;
   logic [4:0] limit_cfg = 5'd16;
   logic up_ready, dn_valid, cmp_ready, up_cmp_valid;
   logic [3:0] dn_id, up_cmp_id, q_level;
   logic [7:0] dn_len;
   logic [31:0] dn_addr;

   axi_issue_gate u_dut (
      .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready), .up_id(up_id),
      .up_len(up_len), .up_addr(up_addr), .dn_valid(dn_valid), .dn_ready(dn_ready),
      .dn_id(dn_id), .dn_len(dn_len), .dn_addr(dn_addr), .cmp_valid(cmp_valid),
      .cmp_ready(cmp_ready), .cmp_id(cmp_id), .cmp_last(cmp_last),
      .up_cmp_valid(up_cmp_valid), .up_cmp_ready(up_cmp_ready), .up_cmp_id(up_cmp_id),
      .limit_cfg(limit_cfg), .space_free(space_free), .beat_release(beat_release),
      .q_level(q_level));

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   bit finished = 0;

   cmd_t mq[$];
   int idcnt[int];
   int out_total = 0, lim_m = 1, resv_m = 0;

   function automatic int clampl(int v);
      if (v == 0) return 1;
      if (v > 16) return 16;
      return v;
   endfunction

   task automatic chk(bit ok, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      mq.delete(); idcnt.delete();
      out_total = 0; lim_m = 1; resv_m = 0;
   endtask

   // One cycle: inputs already set at the falling edge.
   task automatic cycle();
      bit e_ur, e_dv, push, pop, ret;
      int eff;
      #1;
      e_ur = (mq.size() < 8);
      eff = (out_total == 0) ? clampl(int'(limit_cfg)) : lim_m;
      e_dv = 0;
      if (mq.size() > 0)
         e_dv = (out_total < eff) && (idcnt.exists(mq[0].id) || idcnt.num() < 8)
                && (mq[0].len + 1 + resv_m <= int'(space_free));
      chk(up_ready == e_ur, "up_ready", up_ready, e_ur);
      chk(int'(q_level) == mq.size(), "q_level", q_level, mq.size());
      chk(dn_valid == e_dv, "dn_valid", dn_valid, e_dv);
      if (e_dv && dn_valid) begin
         chk(int'(dn_id) == mq[0].id, "dn_id", dn_id, mq[0].id);
         chk(int'(dn_len) == mq[0].len, "dn_len", dn_len, mq[0].len);
         chk(int'(dn_addr) == mq[0].addr, "dn_addr", dn_addr, mq[0].addr);
      end
      chk(up_cmp_valid == cmp_valid, "R9 up_cmp_valid", up_cmp_valid, cmp_valid);
      chk(up_cmp_id == cmp_id, "R9 up_cmp_id", up_cmp_id, cmp_id);
      chk(cmp_ready == up_cmp_ready, "R9 cmp_ready", cmp_ready, up_cmp_ready);
      push = up_valid && e_ur;
      pop  = e_dv && dn_ready;
      ret  = cmp_valid && up_cmp_ready && cmp_last && idcnt.exists(int'(cmp_id)) && out_total > 0;
      @(posedge clk);
      if (out_total == 0) lim_m = clampl(int'(limit_cfg));
      if (beat_release && resv_m > 0) resv_m--;
      if (pop) begin
         cmd_t h = mq.pop_front();
         resv_m += h.len + 1;
         out_total++;
         if (idcnt.exists(h.id)) idcnt[h.id]++; else idcnt[h.id] = 1;
      end
      if (ret) begin
         out_total--;
         idcnt[int'(cmp_id)]--;
         if (idcnt[int'(cmp_id)] == 0) idcnt.delete(int'(cmp_id));
      end
      if (push) mq.push_back('{int'(up_id), int'(up_len), int'(up_addr)});
      @(negedge clk);
   endtask

   task automatic idle();
      up_valid = 0; dn_ready = 0; cmp_valid = 0; cmp_last = 0;
      up_cmp_ready = 0; beat_release = 0;
   endtask

   task automatic send(int id, int len, int addr);
      up_valid = 1; up_id = 4'(id); up_len = 8'(len); up_addr = 32'(addr);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic complete_one();
      int k;
      void'(idcnt.first(k));
      cmp_valid = 1; cmp_last = 1; up_cmp_ready = 1; cmp_id = 4'(k);
      cycle();
      cmp_valid = 0; cmp_last = 0; up_cmp_ready = 0;
   endtask

   task automatic drain_all();
      idle();
      for (int g = 0; g < 400 && (out_total > 0 || resv_m > 0); g++) begin
         if (out_total > 0) begin
            int k;
            void'(idcnt.first(k));
            cmp_valid = 1; cmp_last = 1; up_cmp_ready = 1; cmp_id = 4'(k);
         end else begin
            cmp_valid = 0; cmp_last = 0;
         end
         beat_release = (resv_m > 0);
         cycle();
      end
      idle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      model_reset();
      // R1: reset state
      cur_req = "R1";
      #1;
      chk(up_ready == 1, "reset up_ready", up_ready, 1);
      chk(dn_valid == 0, "reset dn_valid", dn_valid, 0);
      chk(q_level == 0, "reset q_level", q_level, 0);
      @(negedge clk);

      // R2: fill with downstream stalled, then issue all
      cur_req = "R2";
      limit_cfg = 16; dn_ready = 0;
      for (int i = 0; i < 10; i++) begin send(i, 0, i * 16); cycle(); end
      up_valid = 0;
      run(2);
      dn_ready = 1;
      run(10);
      drain_all();

      // R3 and R8: ninth distinct ID blocks, and the command behind waits
      cur_req = "R3";
      dn_ready = 1;
      for (int i = 0; i < 9; i++) begin send(i, 1, 256 + i); cycle(); end
      cur_req = "R8";
      send(3, 0, 999); cycle();
      up_valid = 0;
      run(5);
      cur_req = "R3";
      complete_one();
      run(4);
      drain_all();

      // R5 then R6: zero limit acts as one; changes wait for idle
      cur_req = "R5";
      limit_cfg = 0; dn_ready = 1;
      for (int i = 0; i < 3; i++) begin send(5, 0, 64 + i); cycle(); end
      up_valid = 0;
      run(3);
      cur_req = "R6";
      limit_cfg = 4;
      run(4);
      complete_one();
      run(4);
      drain_all();

      // R4: limit above maximum saturates at 16, shared ID
      cur_req = "R4";
      limit_cfg = 31; dn_ready = 1;
      for (int i = 0; i < 22; i++) begin send(2, 0, i); cycle(); end
      up_valid = 0;
      run(4);
      drain_all();

      // R7: data space reservation
      cur_req = "R7";
      limit_cfg = 16; space_free = 10; dn_ready = 1;
      for (int i = 0; i < 3; i++) begin send(1, 3, 512 + i); cycle(); end
      up_valid = 0;
      run(3);
      for (int i = 0; i < 3; i++) begin beat_release = 1; cycle(); end
      beat_release = 0;
      run(2);
      drain_all();
      space_free = 255;

      // R9: mixed traffic
      cur_req = "R9";
      for (int c = 0; c < 600; c++) begin
         up_valid = 1'($urandom % 2);
         up_id = 4'($urandom % 12);
         up_len = 8'($urandom % 4);
         up_addr = $urandom;
         dn_ready = 1'($urandom % 2);
         up_cmp_ready = 1'($urandom % 2);
         cmp_last = 1'(($urandom % 3) != 0);
         cmp_valid = 0;
         if (out_total > 0 && ($urandom % 2) == 1) begin
            int keys[$];
            foreach (idcnt[k]) keys.push_back(k);
            cmp_valid = 1;
            cmp_id = 4'(keys[$urandom % keys.size()]);
         end
         beat_release = (resv_m > 0) && (($urandom % 2) == 1);
         space_free = 8'(24 + $urandom % 40);
         if (c % 50 == 0) limit_cfg = 5'($urandom % 20);
         cycle();
      end
      space_free = 255;
      drain_all();

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule